// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small accumulator processor. It runs one instruction at a time as a chain of explicit register transfers. It keeps a program counter (PC), a memory address register (MAR), a memory data register (MDR), an instruction register (IR), an accumulator (ACC) and a four-bit status word. Every memory access places the MAR on an outbound address bus. Read data returns into the MDR, and write data leaves from the MDR. Separate read and write strobes qualify each access.

The memory port has no valid/ready handshake and applies no back-pressure. The memory is synchronous with a fixed latency of one cycle, and it must accept a strobe in the cycle it is asserted. A read strobed in one cycle is captured into the MDR on the following cycle. A write strobe is high for one cycle, with the MDR on the write data lines.

The interrupt request is sampled only at the boundary step between instructions. It is ignored while an interrupt is already being serviced. Each micro-step has a four-bit code, shown on a debug output.

Top module: `acc_core`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the step code is 0 and both memory strobes are low. The status output is zero, and the first fetch reads address 0.
- R2: The fetch runs step codes 0,1,2,3,4 and then decode 5. Step 0 copies PC into MAR. Step 1 asserts the read strobe with MAR on the address bus. Step 2 loads MDR from the read data. Step 3 adds one to PC. Step 4 copies MDR into IR.
- R3: Decode splits IR into an opcode in bits 15:12 and a 12-bit address operand in bits 11:0. It loads the operand into MAR.
- R4: LOAD (opcode 1) copies the memory word into ACC, and AND (opcode 5) writes ACC AND the word into ACC. Both update Z and N and leave C and V unchanged. The status word has C in bit 0, Z in bit 1, N in bit 2 and V in bit 3.
- R5: ADD (opcode 3) writes ACC + word into ACC. C is the carry out, V is signed overflow, Z means the result is zero and N is the result's bit 15.
- R6: SUB (opcode 4) writes ACC - word into ACC. C is set when a borrow occurs (ACC below the word, unsigned), and V is signed overflow. Z and N follow the same rules as for ADD.
- R7: STORE (opcode 2) writes ACC to the operand address with a write strobe that lasts exactly one cycle.
- R8: JUMP (6) always loads the operand into PC. JUMP-IF-ZERO (7) does so only when Z is 1, and JUMP-IF-NEGATIVE (8) only when N is 1.
- R9: Opcodes 0 and 10 to 14 have no effect. ACC, the status word and memory stay unchanged, and execution goes on with the next word.
- R10: An interrupt request is taken only at the boundary step (code 13), after the current instruction completes. Entry (code 14) saves PC, ACC and the status word, loads PC with the vector (default 0x080) and masks any further requests.
- R11: Return (opcode 9) restores the saved PC, ACC and status word and clears the mask. A request held high during the service routine causes no second entry.
- R12: HALT (opcode 15) enters step code 15. The core stays there, with no memory strobes, until reset.
- R13: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Address bus, driven from MAR |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata on the next cycle |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | 16 | Write data, driven from MDR |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| irq | input | 1 | Interrupt request, level |
| status | output | 4 | Status word {V,N,Z,C} |
| dbg_step | output | 4 | Current micro-step code |

## Verification
The assertions check the following on every cycle: the fetch step ordering, the one-cycle write strobe, the exclusive strobes, that HALT is permanent, that interrupt entry happens only after the boundary step and that masking holds, and that unconditional jumps and the reset state are correct. Arithmetic results and flag values, store contents, the no-op opcodes and the full save and restore around a service routine can only be seen in the bench scenarios. These scenarios run short random and directed programs and compare memory and the status output with values the bench computes itself.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    ST_F_MAR   = 4'd0,
    ST_F_READ  = 4'd1,
    ST_F_MDR   = 4'd2,
    ST_F_INC   = 4'd3,
    ST_F_IR    = 4'd4,
    ST_DECODE  = 4'd5,
    ST_X_READ  = 4'd6,
    ST_X_MDR   = 4'd7,
    ST_X_ALU   = 4'd8,
    ST_X_STPRE = 4'd9,
    ST_X_WRITE = 4'd10,
    ST_X_JUMP  = 4'd11,
    ST_X_RET   = 4'd12,
    ST_BOUND   = 4'd13,
    ST_IRQ     = 4'd14,
    ST_HALT    = 4'd15
  } step_t;

  localparam logic [3:0] OPC_LOAD  = 4'd1;
  localparam logic [3:0] OPC_STORE = 4'd2;
  localparam logic [3:0] OPC_ADD   = 4'd3;
  localparam logic [3:0] OPC_SUB   = 4'd4;
  localparam logic [3:0] OPC_AND   = 4'd5;
  localparam logic [3:0] OPC_JMP   = 4'd6;
  localparam logic [3:0] OPC_JZ    = 4'd7;
  localparam logic [3:0] OPC_JN    = 4'd8;
  localparam logic [3:0] OPC_RET   = 4'd9;
  localparam logic [3:0] OPC_HALT  = 4'd15;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_AND  = 2'd3
  } alu_op_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  alu_op_t           op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [3:0]        flags_in,
  output logic [WORD_W-1:0] res,
  output logic [3:0]        flags_out
);
  localparam int MSB = WORD_W - 1;

  logic [WORD_W:0] wide;

  always_comb begin
    wide      = '0;
    res       = b;
    flags_out = flags_in;
    unique case (op)
      ALU_ADD: begin
        wide             = {1'b0, a} + {1'b0, b};
        res              = wide[MSB:0];
        flags_out[FLG_C] = wide[WORD_W];
        flags_out[FLG_V] = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
      end
      ALU_SUB: begin
        wide             = {1'b0, a} - {1'b0, b};
        res              = wide[MSB:0];
        flags_out[FLG_C] = wide[WORD_W];
        flags_out[FLG_V] = (a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]);
      end
      ALU_AND:  res = a & b;
      default:  res = b;
    endcase
    flags_out[FLG_Z] = (res == '0);
    flags_out[FLG_N] = res[MSB];
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  input  logic       irq,
  input  logic       masked,
  output step_t      step
);
  step_t nxt;

  always_comb begin
    nxt = step;
    unique case (step)
      ST_F_MAR:   nxt = ST_F_READ;
      ST_F_READ:  nxt = ST_F_MDR;
      ST_F_MDR:   nxt = ST_F_INC;
      ST_F_INC:   nxt = ST_F_IR;
      ST_F_IR:    nxt = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_LOAD, OPC_ADD, OPC_SUB, OPC_AND: nxt = ST_X_READ;
          OPC_STORE:                           nxt = ST_X_STPRE;
          OPC_JMP, OPC_JZ, OPC_JN:             nxt = ST_X_JUMP;
          OPC_RET:                             nxt = ST_X_RET;
          OPC_HALT:                            nxt = ST_HALT;
          default:                             nxt = ST_BOUND;
        endcase
      end
      ST_X_READ:  nxt = ST_X_MDR;
      ST_X_MDR:   nxt = ST_X_ALU;
      ST_X_ALU:   nxt = ST_BOUND;
      ST_X_STPRE: nxt = ST_X_WRITE;
      ST_X_WRITE: nxt = ST_BOUND;
      ST_X_JUMP:  nxt = ST_BOUND;
      ST_X_RET:   nxt = ST_BOUND;
      ST_BOUND:   nxt = (irq && !masked) ? ST_IRQ : ST_F_MAR;
      ST_IRQ:     nxt = ST_F_MAR;
      ST_HALT:    nxt = ST_HALT;
      default:    nxt = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_F_MAR;
    else     step <= nxt;
  end

  a_r2_ir_after_inc: assert property (@(posedge clk) disable iff (rst)
    (step == ST_F_IR) |-> ($past(step) == ST_F_INC));
  a_r2_mdr_after_read: assert property (@(posedge clk) disable iff (rst)
    (step == ST_F_MDR) |-> ($past(step) == ST_F_READ));
  a_r10_entry_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (step == ST_IRQ) |-> ($past(step) == ST_BOUND));
  a_r11_masked_no_entry: assert property (@(posedge clk) disable iff (rst)
    (step == ST_BOUND && masked) |=> (step == ST_F_MAR));
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    (step == ST_HALT) |=> (step == ST_HALT));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VECTOR = 12'h080
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_we,
  output logic [ADDR_W+3:0]    mem_wdata,
  input  logic [ADDR_W+3:0]    mem_rdata,
  input  logic                 irq,
  output logic [3:0]           status,
  output logic [3:0]           dbg_step
);
  localparam int OP_W   = 4;
  localparam int WORD_W = OP_W + ADDR_W;

  logic [ADDR_W-1:0] pc, mar, sh_pc;
  logic [WORD_W-1:0] mdr, ir, acc, sh_acc;
  logic [3:0]        sr, sh_sr;
  logic              masked;
  step_t             step;

  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] operand;
  alu_op_t           alu_op;
  logic [WORD_W-1:0] alu_res;
  logic [3:0]        alu_flags;
  logic              take_jump;

  assign opcode  = ir[WORD_W-1 -: OP_W];
  assign operand = ir[ADDR_W-1:0];

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .irq    (irq),
    .masked (masked),
    .step   (step)
  );

  always_comb begin
    case (opcode)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_SUB: alu_op = ALU_SUB;
      OPC_AND: alu_op = ALU_AND;
      default: alu_op = ALU_PASS;
    endcase
    case (opcode)
      OPC_JMP: take_jump = 1'b1;
      OPC_JZ:  take_jump = sr[FLG_Z];
      OPC_JN:  take_jump = sr[FLG_N];
      default: take_jump = 1'b0;
    endcase
  end

  acc_alu #(.WORD_W(WORD_W)) u_alu (
    .op        (alu_op),
    .a         (acc),
    .b         (mdr),
    .flags_in  (sr),
    .res       (alu_res),
    .flags_out (alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      mar    <= '0;
      mdr    <= '0;
      ir     <= '0;
      acc    <= '0;
      sr     <= '0;
      sh_pc  <= '0;
      sh_acc <= '0;
      sh_sr  <= '0;
      masked <= 1'b0;
    end else begin
      unique case (step)
        ST_F_MAR:   mar <= pc;
        ST_F_MDR:   mdr <= mem_rdata;
        ST_F_INC:   pc  <= pc + 1'b1;
        ST_F_IR:    ir  <= mdr;
        ST_DECODE:  mar <= operand;
        ST_X_MDR:   mdr <= mem_rdata;
        ST_X_ALU: begin
          acc <= alu_res;
          sr  <= alu_flags;
        end
        ST_X_STPRE: mdr <= acc;
        ST_X_JUMP:  if (take_jump) pc <= mar;
        ST_X_RET: begin
          pc     <= sh_pc;
          acc    <= sh_acc;
          sr     <= sh_sr;
          masked <= 1'b0;
        end
        ST_IRQ: begin
          sh_pc  <= pc;
          sh_acc <= acc;
          sh_sr  <= sr;
          pc     <= VECTOR;
          masked <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_rd    = (step == ST_F_READ) || (step == ST_X_READ);
  assign mem_we    = (step == ST_X_WRITE);
  assign mem_wdata = mdr;
  assign status    = sr;
  assign dbg_step  = step;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (step == ST_F_MAR && pc == '0 && sr == '0 && !mem_we && !mem_rd));
  a_r7_we_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  a_r7_wdata_is_acc: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc));
  a_r8_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (step == ST_X_JUMP && opcode == OPC_JMP) |=> (pc == $past(mar)));
  a_r10_mask_on_entry: assert property (@(posedge clk) disable iff (rst)
    (step == ST_IRQ) |=> (masked && pc == VECTOR));
  a_r13_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we));
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq = 1'b0;
  logic [3:0]  status, dbg_step;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int we_cnt, entry_cnt, bad_entry;
  logic [15:0] mem [256];

  always #2.5 clk = ~clk;

  acc_core u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq),
    .status(status), .dbg_step(dbg_step)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] model(input logic [3:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic [3:0] f);
    logic [16:0] w;
    logic [15:0] r;
    logic [3:0]  nf;
    nf = f;
    r  = b;
    case (op)
      4'd3: begin
        w = {1'b0, a} + {1'b0, b}; r = w[15:0];
        nf[0] = w[16]; nf[3] = (a[15] == b[15]) && (r[15] != a[15]);
      end
      4'd4: begin
        w = {1'b0, a} - {1'b0, b}; r = w[15:0];
        nf[0] = w[16]; nf[3] = (a[15] != b[15]) && (r[15] != a[15]);
      end
      4'd5: r = a & b;
      default: r = b;
    endcase
    nf[1] = (r == 16'h0);
    nf[2] = r[15];
    return {nf, r};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic run(input bit irq_mode);
    int n;
    logic [3:0] prev;
    bit raised;
    we_cnt = 0; entry_cnt = 0; bad_entry = 0; raised = 0; n = 0;
    prev = dbg_step;
    while (dbg_step != 4'd15 && n < 3000) begin
      @(negedge clk);
      n++;
      if (mem_we) we_cnt++;
      if (dbg_step == 4'd14) begin
        entry_cnt++;
        if (prev != 4'd13) bad_entry++;
      end
      if (irq_mode) begin
        if (dbg_step == 4'd5 && !raised) begin irq = 1'b1; raised = 1; end
        if (dbg_step == 4'd12 && irq) irq = 1'b0;
      end
      prev = dbg_step;
    end
    irq = 1'b0;
    check(dbg_step == 4'd15, "R12 program reached halt", dbg_step, 4'd15);
  endtask

  initial begin
    logic [15:0] a, b, c, r;
    logic [19:0] m;
    logic [3:0]  op, f;
    void'($urandom(32'd4242));

    clear_mem();
    mem[0] = 16'h1040; mem[1] = 16'h2050; mem[2] = 16'hF000; mem[8'h40] = 16'h1234;
    repeat (3) @(negedge clk);
    check(dbg_step == 4'd0 && !mem_rd && !mem_we, "R1 step/strobes in reset",
          {dbg_step, mem_rd, mem_we}, 32'h0);
    check(status == 4'h0, "R1 status in reset", status, 4'h0);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check(dbg_step == 4'(k), "R2 fetch step order", dbg_step, k);
      if (k == 1) check(mem_rd && mem_addr == 12'h000, "R1 R2 first fetch reads address 0",
                        {mem_rd, mem_addr}, {1'b1, 12'h000});
      @(negedge clk);
    end
    check(dbg_step == 4'd6 && mem_rd && mem_addr == 12'h040, "R3 operand into MAR",
          {dbg_step, mem_addr}, {4'd6, 12'h040});
    run(0);
    check(mem[8'h50] == 16'h1234, "R4 R7 load then store", mem[8'h50], 16'h1234);
    check(we_cnt == 1, "R7 one write strobe cycle", we_cnt, 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (dbg_step != 4'd15 || mem_rd || mem_we)
        check(0, "R12 halt permanent", {dbg_step, mem_rd, mem_we}, {4'd15, 2'b00});
    end
    check(1, "R12 halt held", 0, 0);

    for (int t = 0; t < 40; t++) begin
      a = $urandom(); b = $urandom(); c = $urandom();
      case ($urandom_range(0, 4))
        0: op = 4'd1; 1: op = 4'd3; 2: op = 4'd4; 3: op = 4'd5; default: op = 4'd4;
      endcase
      if (t == 0) begin a = 16'h7FFF; b = 16'h0001; op = 4'd4; c = 16'h8000; end
      if (t == 1) begin a = 16'hFFFF; b = 16'h0001; op = 4'd5; c = 16'h00FF; end
      if (t == 2) begin a = 16'h0000; b = 16'h0000; op = 4'd4; c = 16'h0001; end
      clear_mem();
      mem[0] = 16'h1040; mem[1] = 16'h3041; mem[2] = {op, 12'h042};
      mem[3] = 16'h2050; mem[4] = 16'hF000;
      mem[8'h40] = a; mem[8'h41] = b; mem[8'h42] = c;
      m = model(4'd1, 16'h0, a, 4'h0);
      m = model(4'd3, m[15:0], b, m[19:16]);
      m = model(op, m[15:0], c, m[19:16]);
      do_reset();
      run(0);
      check(mem[8'h50] == m[15:0], "R4 R5 R6 random result", mem[8'h50], m[15:0]);
      check(status == m[19:16], "R4 R5 R6 random flags", status, m[19:16]);
    end

    for (int v = 0; v < 6; v++) begin
      clear_mem();
      case (v / 2)
        0: op = 4'd7; 1: op = 4'd8; default: op = 4'd6;
      endcase
      mem[0] = 16'h1040; mem[1] = {op, 12'h005}; mem[2] = 16'h1041; mem[3] = 16'h2050;
      mem[4] = 16'hF000; mem[5] = 16'h1042; mem[6] = 16'h2050; mem[7] = 16'hF000;
      mem[8'h41] = 16'h1111; mem[8'h42] = 16'h2222;
      if (op == 4'd7) mem[8'h40] = (v % 2) ? 16'h0005 : 16'h0000;
      else if (op == 4'd8) mem[8'h40] = (v % 2) ? 16'h0005 : 16'h8000;
      else mem[8'h40] = 16'h0005;
      r = ((v % 2) == 0 || op == 4'd6) ? 16'h2222 : 16'h1111;
      do_reset();
      run(0);
      check(mem[8'h50] == r, "R8 jump outcome", mem[8'h50], r);
    end

    for (int u = 0; u < 6; u++) begin
      clear_mem();
      op = (u == 0) ? 4'd0 : 4'(9 + u);
      mem[0] = 16'h1040; mem[1] = 16'h3041; mem[2] = {op, 12'h060};
      mem[3] = 16'h2050; mem[4] = 16'hF000;
      mem[8'h40] = 16'hFFFF; mem[8'h41] = 16'h0002; mem[8'h60] = 16'hABCD;
      do_reset();
      run(0);
      check(mem[8'h50] == 16'h0001 && status == 4'b0001, "R9 undefined opcode is no-op",
            {mem[8'h50], status}, {16'h0001, 4'b0001});
      check(mem[8'h60] == 16'hABCD, "R9 memory untouched", mem[8'h60], 16'hABCD);
    end

    clear_mem();
    mem[0] = 16'h1040; mem[1] = 16'h3041; mem[2] = 16'h2050; mem[3] = 16'hF000;
    mem[8'h80] = 16'h1042; mem[8'h81] = 16'h2051; mem[8'h82] = 16'h9000;
    mem[8'h40] = 16'h0007; mem[8'h41] = 16'h0001; mem[8'h42] = 16'h8000;
    do_reset();
    run(1);
    check(entry_cnt == 1, "R10 R11 single entry while masked", entry_cnt, 1);
    check(bad_entry == 0, "R10 entry only after boundary", bad_entry, 0);
    check(mem[8'h51] == 16'h8000, "R10 service routine ran", mem[8'h51], 16'h8000);
    check(mem[8'h50] == 16'h0008, "R11 ACC and PC restored", mem[8'h50], 16'h0008);
    check(status == 4'h0, "R11 status restored", status, 4'h0);
    check(we_cnt == 2, "R7 R13 two stores", we_cnt, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule